// File: doc/BRIEF.md
# Multi-Lane Skew-Absorbing Octet Aligner

This block sits in a serial-link receiver after the per-lane decoders. Each lane delivers one decoded octet per link-clock cycle with a flag that marks control characters. Physical routing makes the lanes arrive with different delays. The block gives every lane its own elastic buffer. A lane starts filling its buffer at the closing alignment character of the initial alignment sequence. It recognises that character by counting the alignment characters (control 0x7C) that arrive while the alignment phase is active.

A release controller watches the shared local multiframe clock strobe. It lets all buffers drain together on the first strobe after every lane holds its closing alignment character. From then on the lanes leave the block time aligned, one octet per lane per cycle, and the transport layer can unpack them. The stored alignment character is discarded at release, so the valid flag covers user octets only.

A lane whose buffer would have to hold more octets than its depth before release sets a sticky overflow error.

Top module: `lane_deskew_aligner`

## Requirements
- R1: After reset, `aligned_valid_o`, `overflow_o` and every bit of `aligned_octets_o` are 0.
- R2: An alignment character is an octet equal to 0x7C with its control flag set; an octet 0x7C without the flag is not counted. Each lane counts alignment characters while `ilas_active_i` is high and stores from its MARK_COUNT-th one (default 4) onward.
- R3: While no release has happened, a low `ilas_active_i` clears every lane's count and buffer, so an interrupted alignment sequence never causes capture.
- R4: Release happens at the first clock edge where `lmfc_edge_i` is high and every lane had already captured at an earlier edge. Strobes before that leave `aligned_valid_o` low.
- R5: `aligned_valid_o` rises one cycle after the release edge. The stored alignment character is dropped, so the first valid octet on each lane is the first user octet that followed it.
- R6: From the first valid cycle on, every lane presents the octet with the same stream position in the same cycle, one new octet per cycle, and `aligned_valid_o` stays high until reset.
- R7: After release, `ilas_active_i` has no effect on the output stream.
- R8: `overflow_o` rises and stays high until reset when a lane must store a new octet while it already holds BUF_DEPTH octets and nothing is being read. A lane that holds exactly BUF_DEPTH octets at the release edge does not overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_octets_i | input | NUM_LANES*8 | Decoded octets, lane n in bits [8n+7:8n] |
| rx_is_k_i | input | NUM_LANES | Control-character flag, one bit per lane |
| lmfc_edge_i | input | 1 | One-cycle strobe at each local multiframe clock rising edge |
| ilas_active_i | input | 1 | High while the initial alignment phase is in progress |
| aligned_octets_o | output | NUM_LANES*8 | Aligned octets, same lane packing as the input |
| aligned_valid_o | output | 1 | Aligned octets hold user data |
| overflow_o | output | 1 | Sticky buffer overflow error |

## Verification
A lane captures at the edge where its closing alignment character is presented. The release edge is the first strobe edge strictly after the latest lane's capture edge. The first user octet appears after the edge that follows the release edge. The bench derives each of these edges from the skews and strobe phase it chose. It samples outputs at the falling edge after each rising edge and compares them with the octet stream position due at that edge. Valid must be low through the release edge itself. The overflow expectation comes from the number of writes the least-skewed lane receives between its capture edge and the release edge.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;
   localparam int OCTET_W = 8;
   typedef logic [OCTET_W-1:0] octet_t;
   // closing character of each alignment multiframe (control code)
   localparam octet_t MARK_CHAR = 8'h7C;
endpackage

// File: rtl/lane_marker_det.sv
module lane_marker_det
   import lane_align_pkg::*;
#(
   parameter int MARK_COUNT = 4
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   flush_i,
   input  logic   ilas_i,
   input  octet_t octet_i,
   input  logic   is_k_i,
   output logic   capture_now_o,
   output logic   captured_o
);
   localparam int CW = (MARK_COUNT > 1) ? $clog2(MARK_COUNT) : 1;
   localparam logic [CW-1:0] LAST_IDX = CW'(MARK_COUNT - 1);

   if (MARK_COUNT < 2) begin : g_bad_count
      $error("lane_marker_det: MARK_COUNT must be at least 2");
   end

   logic [CW-1:0] seen_q;
   logic          captured_q;
   logic          is_mark;

   assign is_mark       = is_k_i && (octet_i == MARK_CHAR);
   assign capture_now_o = !captured_q && ilas_i && is_mark && (seen_q == LAST_IDX);
   assign captured_o    = captured_q;

   always_ff @(posedge clk) begin
      if (!rst_n || flush_i) begin
         seen_q     <= '0;
         captured_q <= 1'b0;
      end else if (capture_now_o) begin
         seen_q     <= '0;
         captured_q <= 1'b1;
      end else if (!captured_q && ilas_i && is_mark) begin
         seen_q <= seen_q + 1'b1;
      end
   end

   // R2: capture only follows a flagged mark seen during the alignment phase
   a_r2_capture_on_mark: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(captured_o) |-> ($past(is_k_i) && $past(ilas_i)));
   // R3: a flush leaves the lane uncaptured
   a_r3_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> !captured_o);
endmodule

// File: rtl/lane_elastic_buf.sv
module lane_elastic_buf
   import lane_align_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   flush_i,
   input  logic   wr_i,
   input  octet_t wdata_i,
   input  logic   rd_i,
   output octet_t rdata_o,
   output logic   ovf_o
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("lane_elastic_buf: DEPTH must be a power of two, at least 2");
   end

   octet_t        mem [DEPTH];
   logic [AW-1:0] wp_q, rp_q;
   logic [CW-1:0] fill_q;
   logic          do_rd, do_wr, full;

   assign full    = (fill_q == FULL_LVL);
   assign do_rd   = rd_i && (fill_q != '0);
   assign do_wr   = wr_i && (!full || do_rd);
   assign rdata_o = mem[rp_q];

   always_ff @(posedge clk) begin
      if (do_wr && !flush_i) mem[wp_q] <= wdata_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q   <= '0;
         rp_q   <= '0;
         fill_q <= '0;
         ovf_o  <= 1'b0;
      end else if (flush_i) begin
         wp_q   <= '0;
         rp_q   <= '0;
         fill_q <= '0;
      end else begin
         if (do_wr) wp_q <= wp_q + 1'b1;
         if (do_rd) rp_q <= rp_q + 1'b1;
         fill_q <= fill_q + CW'(do_wr) - CW'(do_rd);
         if (wr_i && full && !do_rd) ovf_o <= 1'b1;
      end
   end

   // R8: occupancy never passes the depth and the error is sticky
   a_r8_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
      fill_q <= FULL_LVL);
   a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> ovf_o);
endmodule

// File: rtl/align_release.sv
module align_release (
   input  logic clk,
   input  logic rst_n,
   input  logic all_cap_i,
   input  logic lmfc_i,
   output logic rel_pulse_o,
   output logic released_o
);
   assign rel_pulse_o = all_cap_i && lmfc_i && !released_o;

   always_ff @(posedge clk) begin
      if (!rst_n)           released_o <= 1'b0;
      else if (rel_pulse_o) released_o <= 1'b1;
   end

   // R4: release only on a strobe with every lane already captured
   a_r4_release_gate: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(released_o) |-> ($past(lmfc_i) && $past(all_cap_i)));
endmodule

// File: rtl/lane_deskew_aligner.sv
module lane_deskew_aligner
   import lane_align_pkg::*;
#(
   parameter int NUM_LANES  = 4,
   parameter int BUF_DEPTH  = 16,
   parameter int MARK_COUNT = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_LANES*OCTET_W-1:0] rx_octets_i,
   input  logic [NUM_LANES-1:0]         rx_is_k_i,
   input  logic                         lmfc_edge_i,
   input  logic                         ilas_active_i,
   output logic [NUM_LANES*OCTET_W-1:0] aligned_octets_o,
   output logic                         aligned_valid_o,
   output logic                         overflow_o
);
   if (NUM_LANES < 1) begin : g_bad_lanes
      $error("lane_deskew_aligner: NUM_LANES must be at least 1");
   end

   logic [NUM_LANES-1:0] cap_now, cap_q, ovf_vec;
   octet_t               head [NUM_LANES];
   logic                 released, rel_pulse, flush, rd_en;

   assign flush = !ilas_active_i && !released;
   assign rd_en = rel_pulse || released;

   for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_lane
      octet_t in_oct;
      assign in_oct = rx_octets_i[ln*OCTET_W +: OCTET_W];

      lane_marker_det #(.MARK_COUNT(MARK_COUNT)) i_det (
         .clk          (clk),
         .rst_n        (rst_n),
         .flush_i      (flush),
         .ilas_i       (ilas_active_i),
         .octet_i      (in_oct),
         .is_k_i       (rx_is_k_i[ln]),
         .capture_now_o(cap_now[ln]),
         .captured_o   (cap_q[ln])
      );

      lane_elastic_buf #(.DEPTH(BUF_DEPTH)) i_buf (
         .clk    (clk),
         .rst_n  (rst_n),
         .flush_i(flush),
         .wr_i   (cap_now[ln] || cap_q[ln]),
         .wdata_i(in_oct),
         .rd_i   (rd_en),
         .rdata_o(head[ln]),
         .ovf_o  (ovf_vec[ln])
      );

      always_ff @(posedge clk) begin
         if (!rst_n)        aligned_octets_o[ln*OCTET_W +: OCTET_W] <= '0;
         else if (released) aligned_octets_o[ln*OCTET_W +: OCTET_W] <= head[ln];
      end
   end

   align_release i_rel (
      .clk        (clk),
      .rst_n      (rst_n),
      .all_cap_i  (&cap_q),
      .lmfc_i     (lmfc_edge_i),
      .rel_pulse_o(rel_pulse),
      .released_o (released)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) aligned_valid_o <= 1'b0;
      else        aligned_valid_o <= released;
   end

   assign overflow_o = |ovf_vec;

   // R5: valid output only once the release controller has fired
   a_r5_valid_after_release: assert property (@(posedge clk) disable iff (!rst_n)
      aligned_valid_o |-> released);
   // R6: the aligned stream does not stop once started
   a_r6_valid_holds: assert property (@(posedge clk) disable iff (!rst_n)
      aligned_valid_o |=> aligned_valid_o);
   // R7: no flush can happen after release
   a_r7_no_late_flush: assert property (@(posedge clk) disable iff (!rst_n)
      $past(released) |-> !flush);
endmodule

// File: tb/test_lane_deskew_aligner.sv
module test_lane_deskew_aligner;
   localparam int NL = 4;
   localparam int DEPTH = 16;
   localparam int MF = 8;
   localparam int S = 40;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NL*8-1:0] rx_octets = '0;
   logic [NL-1:0]   rx_is_k = '0;
   logic          lmfc = 1'b0;
   logic          ilas = 1'b0;
   logic [NL*8-1:0] al_octets;
   logic          al_valid;
   logic          ovf;

   int n_checks = 0;
   int n_fail = 0;
   int cyc = 0;

   always #10 clk = ~clk;

   lane_deskew_aligner #(.NUM_LANES(NL), .BUF_DEPTH(DEPTH), .MARK_COUNT(4)) i_lane_deskew_aligner (
      .clk(clk), .rst_n(rst_n), .rx_octets_i(rx_octets), .rx_is_k_i(rx_is_k),
      .lmfc_edge_i(lmfc), .ilas_active_i(ilas),
      .aligned_octets_o(al_octets), .aligned_valid_o(al_valid), .overflow_o(ovf)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cyc);
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   task automatic check(input string req, input bit ok, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] user_oct(input int k);
      return 8'((k * 3) + 5);
   endfunction

   // returns {control flag, octet}
   function automatic logic [8:0] ilas_oct(input int m);
      int p = m % MF;
      if (p == 0)      return {1'b1, 8'h1C};
      if (p == MF - 1) return {1'b1, 8'h7C};
      if (p == 2)      return {1'b0, 8'h7C};   // unflagged look-alike (R2)
      return {1'b0, 8'(m + 8'h40)};
   endfunction

   function automatic logic [8:0] stream(input int n, input bit abort);
      if (n >= 4 * MF) return {1'b0, user_oct(n - 4 * MF)};
      if (n >= 0)      return ilas_oct(n);
      if (abort && n >= -30 && n < -14) return ilas_oct(n + 30);
      return {1'b1, 8'hBC};
   endfunction

   task automatic do_reset();
      rst_n = 1'b0; ilas = 1'b0; lmfc = 1'b0;
      rx_octets = {NL{8'hBC}}; rx_is_k = '1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run_case(input string name, input int sk0, input int sk1, input int sk2,
                           input int sk3, input int rel_off, input bit abort);
      int sk[NL];
      int dmax, dmin, lastcap, rel, phase, bad4, bad6, bad7, first_bad;
      bit exp_ovf, first_valid;
      sk[0] = sk0; sk[1] = sk1; sk[2] = sk2; sk[3] = sk3;
      dmax = sk0; dmin = sk0;
      for (int l = 1; l < NL; l++) begin
         if (sk[l] > dmax) dmax = sk[l];
         if (sk[l] < dmin) dmin = sk[l];
      end
      lastcap = S + 4 * MF - 1 + dmax;
      rel = lastcap + rel_off;
      phase = (MF - (rel % MF)) % MF;
      exp_ovf = (dmax - dmin + rel_off) > DEPTH;
      bad4 = 0; bad6 = 0; bad7 = 0; first_bad = 0; first_valid = 1'b0;
      do_reset();
      for (int c = 0; c <= rel + 40; c++) begin
         if (c > 0) begin
            int prev = c - 1;
            if (prev <= rel && al_valid) bad4++;
            if (prev == rel + 1) begin
               first_valid = al_valid;
               for (int l = 0; l < NL; l++)
                  if (al_octets[l*8 +: 8] != user_oct(0)) first_bad++;
            end
            if (prev >= rel + 1) begin
               int mism = al_valid ? 0 : 1;
               for (int l = 0; l < NL; l++)
                  if (al_octets[l*8 +: 8] != user_oct(prev - rel - 1)) mism++;
               if (mism != 0) begin
                  if (prev < rel + 3) bad6++;
                  else bad7++;
               end
            end
         end
         for (int l = 0; l < NL; l++) begin
            logic [8:0] s = stream(c - S - sk[l], abort);
            rx_is_k[l] = s[8];
            rx_octets[l*8 +: 8] = s[7:0];
         end
         lmfc = ((c + phase) % MF) == 0;
         ilas = (c >= S && c < rel + 3) ||
                (abort && c >= S - 30 && c < S - 14 + dmax + 1);
         @(negedge clk);
      end
      $display("[TB] case %s: release edge %0d", name, rel);
      check("R4 valid low before release", bad4 == 0, bad4, 0);
      check("R8 overflow flag", ovf == exp_ovf, int'(ovf), int'(exp_ovf));
      if (!exp_ovf) begin
         check(abort ? "R3 first user octet after aborted sequence" : "R2 R5 first user octet",
               first_valid && first_bad == 0, first_bad, 0);
         check("R6 lanes aligned and continuous", bad6 == 0, bad6, 0);
         check("R7 stream unaffected after alignment phase ends", bad7 == 0, bad7, 0);
      end else begin
         check("R4 release still occurs with overflow", al_valid == 1'b1, int'(al_valid), 1);
      end
   endtask

   task automatic t_reset();
      do_reset();
      check("R1 valid after reset", al_valid == 1'b0, int'(al_valid), 0);
      check("R1 overflow after reset", ovf == 1'b0, int'(ovf), 0);
      check("R1 octets after reset", al_octets == '0, int'(al_octets), 0);
   endtask

   initial begin
      t_reset();
      run_case("mixed_skew", 0, 2, 5, 1, 3, 1'b0);
      run_case("strobe_at_capture", 3, 0, 1, 4, MF, 1'b0);
      run_case("aborted_sequence", 1, 4, 0, 2, 5, 1'b1);
      run_case("no_skew", 0, 0, 0, 0, 1, 1'b0);
      run_case("fill_exactly_depth", 0, 0, 0, 15, 1, 1'b0);
      run_case("overflow", 0, 0, 0, 15, 2, 1'b0);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule